// File: doc/BRIEF.md
# Single-Precision Denormal Flush Stage

This block is one register stage placed after a single-precision floating-point arithmetic core. For each operation it receives the rounded result word from the core. It also receives flags that say whether the unrounded result falls below the normal range, whether the result is exact, and whether any input operand is denormal. From these and the two mode controls it produces the final result word, the underflow and inexact cause flags, a result write enable and a trap request.

In performance mode the block never traps. Tiny results are replaced by a signed zero or by the smallest normal number. Denormal input operands always produce a signed zero. Each such replacement sets a sticky flush flag, which stays set until software clears it. In precise mode any tiny result or denormal input raises a trap request and suppresses the result write. The flush-select control has no effect in precise mode. Normal results pass through in both modes.

Top module: `dnf_top`

## Requirements
- R1: An operation with no tiny result and no denormal input, and with exact set, outputs the rounded word unchanged with underflow=0, inexact=0, write enable=1 and trap=0.
- R2: The same case with exact clear outputs the rounded word with underflow=0, inexact=1, write enable=1 and trap=0.
- R3: In performance mode (perf=1) with flush-select=1, a tiny result with no denormal input outputs the minimum normal word {sign, 8'h01, 23'h0} when rounding is 10 (toward +inf) with sign 0, or 11 (toward -inf) with sign 1. Otherwise it outputs {sign, 31'h0}. In every case underflow=1, inexact=1, write enable=1 and trap=0. Rounding encoding: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf.
- R4: In performance mode with flush-select=0, a tiny result with no denormal input outputs {sign, 31'h0} in every rounding mode, with underflow=1, inexact=1 and trap=0.
- R5: In performance mode, a denormal input outputs {sign, 31'h0} whatever the rounding mode, flush-select and tiny flag, with underflow=1, inexact=1 and trap=0.
- R6: The sticky flush flag sets on the output cycle of any performance-mode flush (R3, R4, R5). It stays set until a cycle with the clear input high. A set and a clear in the same cycle leave it set.
- R7: In precise mode (perf=0), a tiny result or a denormal input gives trap=1, underflow=1, inexact=1, write enable=0 and a result word of zero, and leaves the sticky flag unchanged.
- R8: In precise mode the flush-select input has no effect on any output.
- R9: Outputs appear one clock after the input is accepted, and valid_o follows valid_i by one cycle. In a cycle with valid_o=0, the result, the flags, the write enable and the trap are all zero.
- R10: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| perf_mode_i | input | 1 | 1 = performance mode, 0 = precise mode |
| flush_sel_i | input | 1 | Tiny-result flush picks its target from the rounding mode |
| rnd_mode_i | input | 2 | Rounding mode (00 nearest, 01 zero, 10 +inf, 11 -inf) |
| res_sign_i | input | 1 | Sign of the result |
| res_tiny_i | input | 1 | Unrounded result is below the normal range |
| res_exact_i | input | 1 | Result needed no rounding |
| in_denorm_i | input | 1 | At least one input operand is denormal |
| rounded_i | input | 32 | Rounded result word from the core |
| sticky_clr_i | input | 1 | Software clear of the sticky flush flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Final result word |
| result_we_o | output | 1 | Result may be written |
| underflow_o | output | 1 | Underflow cause flag |
| inexact_o | output | 1 | Inexact cause flag |
| trap_o | output | 1 | Trap request |
| flush_sticky_o | output | 1 | Sticky flush flag |

## Verification
The bench runs all four rounding modes with both signs on tiny results. A design that chose the minimum normal for the wrong sign or direction would output 0x00800000 where a zero is expected, or the reverse. It combines a denormal input with a tiny result under round-up, which catches a design that lets the input flush take the minimum normal. Precise mode runs with flush-select both set and clear, so a design that consulted that bit there would produce a result instead of a trap. Set and clear of the sticky flag land in the same cycle, and idle cycles are placed between operations, to expose a wrong clear priority and flags that leak into invalid cycles.

// File: rtl/dnf_pkg.sv
package dnf_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_POS  = 2'b10,
    RND_NEG  = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'b00,
    ACT_ZERO  = 2'b01,
    ACT_DIR   = 2'b10,
    ACT_TRAP  = 2'b11
  } act_e;
endpackage

// File: rtl/dnf_classify.sv
module dnf_classify
  import dnf_pkg::*;
(
  input  logic perf_mode_i,
  input  logic flush_sel_i,
  input  logic res_tiny_i,
  input  logic in_denorm_i,
  output act_e act_o
);
  always_comb begin
    if (!res_tiny_i && !in_denorm_i) act_o = ACT_PASS;
    else if (!perf_mode_i)           act_o = ACT_TRAP;
    else if (in_denorm_i)            act_o = ACT_ZERO;  // inputs only ever go to zero
    else if (flush_sel_i)            act_o = ACT_DIR;
    else                             act_o = ACT_ZERO;
  end
endmodule

// File: rtl/dnf_select.sv
module dnf_select
  import dnf_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  localparam int unsigned W = 1 + EW + MW
) (
  input  act_e         act_i,
  input  logic [1:0]   rnd_i,
  input  logic         sign_i,
  input  logic         exact_i,
  input  logic [W-1:0] rounded_i,
  output logic [W-1:0] result_o,
  output logic         we_o,
  output logic         uf_o,
  output logic         ix_o,
  output logic         trap_o
);
  logic [W-1:0] zero_w, minn_w;
  logic         away;

  assign zero_w = {sign_i, {(W-1){1'b0}}};
  assign minn_w = {sign_i, {(EW-1){1'b0}}, 1'b1, {MW{1'b0}}};
  assign away   = (rnd_i == RND_POS && !sign_i) || (rnd_i == RND_NEG && sign_i);

  always_comb begin
    result_o = '0;
    we_o     = 1'b1;
    uf_o     = 1'b1;
    ix_o     = 1'b1;
    trap_o   = 1'b0;
    unique case (act_i)
      ACT_PASS: begin
        result_o = rounded_i;
        uf_o     = 1'b0;
        ix_o     = !exact_i;
      end
      ACT_ZERO: result_o = zero_w;
      ACT_DIR:  result_o = away ? minn_w : zero_w;
      ACT_TRAP: begin
        we_o   = 1'b0;
        trap_o = 1'b1;
      end
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/dnf_sticky.sv
module dnf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_o <= 1'b0;
    else if (set_i)  sticky_o <= 1'b1;  // set wins over clear
    else if (clr_i)  sticky_o <= 1'b0;
  end
endmodule

// File: rtl/dnf_top.sv
module dnf_top
  import dnf_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned MW = MAN_W,
  localparam int unsigned W = 1 + EW + MW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         perf_mode_i,
  input  logic         flush_sel_i,
  input  logic [1:0]   rnd_mode_i,
  input  logic         res_sign_i,
  input  logic         res_tiny_i,
  input  logic         res_exact_i,
  input  logic         in_denorm_i,
  input  logic [W-1:0] rounded_i,
  input  logic         sticky_clr_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic         underflow_o,
  output logic         inexact_o,
  output logic         trap_o,
  output logic         flush_sticky_o
);
  act_e         act;
  logic [W-1:0] sel_res;
  logic         sel_we, sel_uf, sel_ix, sel_trap;

  dnf_classify u_cls (
    .perf_mode_i (perf_mode_i),
    .flush_sel_i (flush_sel_i),
    .res_tiny_i  (res_tiny_i),
    .in_denorm_i (in_denorm_i),
    .act_o       (act)
  );

  dnf_select #(.EW(EW), .MW(MW)) u_sel (
    .act_i     (act),
    .rnd_i     (rnd_mode_i),
    .sign_i    (res_sign_i),
    .exact_i   (res_exact_i),
    .rounded_i (rounded_i),
    .result_o  (sel_res),
    .we_o      (sel_we),
    .uf_o      (sel_uf),
    .ix_o      (sel_ix),
    .trap_o    (sel_trap)
  );

  dnf_sticky u_stk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (valid_i && (act == ACT_ZERO || act == ACT_DIR)),
    .clr_i    (sticky_clr_i),
    .sticky_o (flush_sticky_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      result_we_o <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
      trap_o      <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      result_o    <= valid_i ? sel_res : '0;
      result_we_o <= valid_i && sel_we;
      underflow_o <= valid_i && sel_uf;
      inexact_o   <= valid_i && sel_ix;
      trap_o      <= valid_i && sel_trap;
    end
  end
endmodule

// File: rtl/dnf_top_chk.sv
module dnf_top_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned MW = 23
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         sticky_clr_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic         underflow_o,
  input logic         inexact_o,
  input logic         trap_o,
  input logic         flush_sticky_o
);
  // R7
  trap_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !result_we_o && underflow_o && inexact_o);
  // R9
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !trap_o && !underflow_o && !inexact_o && !result_we_o && result_o == '0);
  // R3
  flush_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !trap_o) |-> (result_o[W-2:0] == '0 || result_o[W-2:0] == (W-1)'(1) << MW));
  // R6
  sticky_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_sticky_o) |-> valid_o && underflow_o && !trap_o);
  // R6
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_sticky_o) && !$past(sticky_clr_i)) |-> flush_sticky_o);
endmodule

bind dnf_top dnf_top_chk #(.W(W), .MW(MW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .sticky_clr_i   (sticky_clr_i),
  .valid_o        (valid_o),
  .result_o       (result_o),
  .result_we_o    (result_we_o),
  .underflow_o    (underflow_o),
  .inexact_o      (inexact_o),
  .trap_o         (trap_o),
  .flush_sticky_o (flush_sticky_o)
);

// File: tb/dnf_top_tb_top.sv
module dnf_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, perf_mode_i = 1'b0, flush_sel_i = 1'b0;
  logic [1:0]  rnd_mode_i = 2'b00;
  logic        res_sign_i = 1'b0, res_tiny_i = 1'b0, res_exact_i = 1'b0, in_denorm_i = 1'b0;
  logic [31:0] rounded_i = '0;
  logic        sticky_clr_i = 1'b0;
  logic        valid_o, result_we_o, underflow_o, inexact_o, trap_o, flush_sticky_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit exp_sticky = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dnf_top dut_i (.*);

  task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [38:0] pack_out();
    return {valid_o, result_o, result_we_o, underflow_o, inexact_o, trap_o, flush_sticky_o};
  endfunction

  // One cycle: drive at negedge, compare at the following negedge.
  task automatic op(input string tag, input bit v, input bit perf, input bit fsel,
                    input bit [1:0] rnd, input bit sgn, input bit tiny, input bit exact,
                    input bit dn, input bit [31:0] rw, input bit clr);
    bit [31:0] e_res;
    bit e_we, e_uf, e_ix, e_tr, flushed;
    valid_i = v; perf_mode_i = perf; flush_sel_i = fsel; rnd_mode_i = rnd;
    res_sign_i = sgn; res_tiny_i = tiny; res_exact_i = exact; in_denorm_i = dn;
    rounded_i = rw; sticky_clr_i = clr;
    e_res = 0; e_we = 0; e_uf = 0; e_ix = 0; e_tr = 0; flushed = 0;
    if (v) begin
      if (!tiny && !dn) begin
        e_res = rw; e_we = 1; e_ix = !exact;
      end else if (!perf) begin
        e_tr = 1; e_uf = 1; e_ix = 1;
      end else begin
        e_we = 1; e_uf = 1; e_ix = 1; flushed = 1;
        e_res = {sgn, 31'h0};
        if (!dn && fsel && ((rnd == 2'b10 && !sgn) || (rnd == 2'b11 && sgn)))
          e_res = {sgn, 31'h0080_0000};
      end
    end
    if (flushed) exp_sticky = 1;
    else if (clr) exp_sticky = 0;
    @(negedge clk_i);
    check(tag, pack_out(), {v, e_res, e_we, e_uf, e_ix, e_tr, exp_sticky});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    check("R10 reset", pack_out(), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 / R2 normal results, both modes
    op("R1 exact", 1, 1, 0, 2'b00, 0, 0, 1, 0, 32'h3f80_0000, 0);
    op("R1 exact precise", 1, 0, 1, 2'b01, 1, 0, 1, 0, 32'hc120_0000, 0);
    op("R2 inexact", 1, 0, 0, 2'b10, 0, 0, 0, 0, 32'h3eaa_aaab, 0);
    op("R2 inexact perf", 1, 1, 1, 2'b11, 1, 0, 0, 0, 32'hbeaa_aaab, 0);
    op("R9 idle", 0, 1, 1, 2'b10, 0, 1, 0, 1, 32'hffff_ffff, 0);
    // R3 all rounding modes and signs
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 2; s++)
        op("R3 dir flush", 1, 1, 1, 2'(r), 1'(s), 1, 0, 0, 32'h0000_0123, 0);
    op("R6 clear", 1, 1, 0, 2'b00, 0, 0, 1, 0, 32'h4000_0000, 1);
    op("R6 cleared", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 0);
    // R4 flush-select clear
    for (int r = 0; r < 4; r++)
      op("R4 zero flush", 1, 1, 0, 2'(r), 1'(r[0]), 1, 0, 0, 32'h8000_0456, 0);
    op("R6 hold", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 0);
    op("R6 set beats clear", 1, 1, 1, 2'b10, 0, 1, 1, 0, 32'h0, 1);
    op("R6 clear", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 1);
    // R5 denormal inputs never take minN
    op("R5 dn up", 1, 1, 1, 2'b10, 0, 1, 0, 1, 32'h0000_0777, 0);
    op("R5 dn down", 1, 1, 1, 2'b11, 1, 0, 1, 1, 32'h3f00_0000, 0);
    op("R5 dn near", 1, 1, 0, 2'b00, 0, 0, 0, 1, 32'h3f00_0000, 0);
    op("R6 clear", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 1);
    // R7 / R8 precise traps with flush-select both ways
    op("R7 tiny trap", 1, 0, 0, 2'b10, 0, 1, 0, 0, 32'h0000_0001, 0);
    op("R8 tiny trap fsel", 1, 0, 1, 2'b10, 0, 1, 0, 0, 32'h0000_0001, 0);
    op("R7 dn trap", 1, 0, 0, 2'b11, 1, 0, 1, 1, 32'hbf80_0000, 0);
    op("R8 dn trap fsel", 1, 0, 1, 2'b11, 1, 0, 1, 1, 32'hbf80_0000, 0);
    op("R6 flush", 1, 1, 1, 2'b11, 1, 1, 0, 0, 32'h8000_0001, 0);
    op("R7 sticky kept", 1, 0, 1, 2'b00, 0, 1, 0, 0, 32'h0, 0);
    op("R9 idle after trap", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h1234_5678, 0);
    op("R1 back to back", 1, 0, 0, 2'b00, 0, 0, 1, 0, 32'h7f7f_ffff, 0);
    op("R2 back to back", 1, 1, 0, 2'b01, 1, 0, 0, 0, 32'hff7f_ffff, 0);
    op("R9 final idle", 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule